// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block drives a synchronous two-wire debug link from the host side. It generates the link clock, owns an active-low target reset line and controls one shared data pin through an output value and an output-enable. The bench models the pad as a split of these signals. A host asks for one of four operations with a start strobe: enter debug mode, leave debug mode, a write transfer, or a read transfer. When the operation is over, the block answers with a one-cycle done pulse.

A write transfer shifts out one to four command bytes and receives nothing. A read transfer shifts out its command bytes, then releases the data pin and clocks in exactly one reply byte. Every level of the link clock lasts `HALF_CYC` system cycles, so the link rate is set by that parameter. The host must choose it so the link clock stays at or below about 30 MHz. Nothing above byte framing is interpreted.

The controller is a single state machine. Its states are:
- `ST_IDLE`: waits for start.
- `ST_ENT_LOW`: reset low, clock low.
- `ST_ENT_CLKH` and `ST_ENT_CLKL`: the entry pulses.
- `ST_ENT_REL`: reset released.
- `ST_EXT_LOW` and `ST_EXT_REL`: the exit pulse.
- `ST_TX_SET` and `ST_TX_HIGH`: one transmitted bit, low half then high half.
- `ST_RX_SET` and `ST_RX_HIGH`: one received bit, pin released.
- `ST_FINISH`: the done cycle.

Each state except `ST_IDLE` and `ST_FINISH` lasts one half period and leaves on the tick. The transitions are:
- `ST_IDLE` goes to `ST_ENT_LOW`, `ST_EXT_LOW` or `ST_TX_SET`, chosen by the operation.
- `ST_ENT_LOW` goes to `ST_ENT_CLKH`.
- `ST_ENT_CLKH` goes to `ST_ENT_CLKL`.
- `ST_ENT_CLKL` goes back to `ST_ENT_CLKH` until the pulse count is reached, and then to `ST_ENT_REL`.
- `ST_ENT_REL` goes to `ST_FINISH`.
- `ST_EXT_LOW` goes to `ST_EXT_REL`, which goes to `ST_FINISH`.
- `ST_TX_SET` goes to `ST_TX_HIGH`.
- `ST_TX_HIGH` goes back to `ST_TX_SET` while bits remain. After the last bit it goes to `ST_RX_SET` for a read and to `ST_FINISH` for a write.
- `ST_RX_SET` goes to `ST_RX_HIGH`.
- `ST_RX_HIGH` goes back to `ST_RX_SET` until eight bits are in, then to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `dbglink_master`

## Requirements
- R1: After reset and whenever no operation is active, the block holds its idle outputs. These are `link_clk` low, `dio_oe` low, `link_rst_n` high, `cmd_ready` high and `done` low.
- R2: Operation code 2 (enter) does the following in order. It drives `link_rst_n` low. It gives exactly `ENTRY_PULSES` (2) rising edges of `link_clk` while reset is low. It then releases `link_rst_n` high, with no clock edge after the release.
- R3: Operation code 3 (exit) holds `link_rst_n` low for one half period and then high again, with no `link_clk` edge at all.
- R4: Operation codes 0 (write) and 1 (read) send `cmd_nbytes_m1`+1 bytes. Byte 0 (`cmd_bytes[7:0]`) goes first, then byte 1 (`cmd_bytes[15:8]`), and so on. Each byte is sent most significant bit first, one bit per rising edge of `link_clk`.
- R5: Each transmitted bit is driven with `dio_oe` high from half a period before its rising edge. It stays unchanged while the clock is high and changes only after the falling edge.
- R6: A write transfer gives no receive clocks, and `rx_byte` is 0 during its done cycle.
- R7: After the last command bit, a read transfer releases the pin (`dio_oe` low) and gives exactly 8 more rising edges. `dio_in` is captured as the clock falls, most significant bit first. The result is on `rx_byte` during the done cycle.
- R8: Within an operation, every high and low level of `link_clk` lasts exactly `HALF_CYC` system cycles.
- R9: `done` is high for exactly one cycle at the end of each operation, and `cmd_ready` is high again on the next cycle.
- R10: `cmd_start` while an operation is active is ignored. The active transfer is unchanged, and no further operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe, taken only when `cmd_ready` is high |
| cmd_op | input | 2 | 0 write, 1 read, 2 enter debug, 3 exit debug |
| cmd_nbytes_m1 | input | $clog2(MAX_BYTES) | Number of command bytes minus one |
| cmd_bytes | input | 8*MAX_BYTES | Command bytes; byte 0 in the low eight bits is sent first |
| cmd_ready | output | 1 | High while idle |
| done | output | 1 | One-cycle end-of-operation pulse |
| rx_byte | output | 8 | Reply byte of a read, valid with `done` |
| link_clk | output | 1 | Link clock, idles low |
| link_rst_n | output | 1 | Active-low target reset |
| dio_out | output | 1 | Value driven onto the shared data pin |
| dio_oe | output | 1 | Data pin drive enable; low releases the pin |
| dio_in | input | 1 | Value read back from the shared data pin |

## Verification
The assertions assume that `dio_in` is synchronous to `clk`. They also assume that every operation code is legal, and that the host loads `cmd_op`, `cmd_nbytes_m1` and `cmd_bytes` together with the strobe. The bench's target model respects this: it changes `dio_in` only on the falling system clock, after it sees a rising link edge with the pin released, and holds that value for the whole high phase. On each falling link edge it inverts the value, so a capture taken at the wrong edge gives a wrong reply. The bench holds the command inputs steady across each strobe, and it raises a second strobe only in the scenario that tests that strobes are ignored while busy.

// File: rtl/dbglink_pkg.sv
package dbglink_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_ENTER = 2'd2,
        OP_EXIT  = 2'd3
    } link_op_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENT_LOW,
        ST_ENT_CLKH,
        ST_ENT_CLKL,
        ST_ENT_REL,
        ST_EXT_LOW,
        ST_EXT_REL,
        ST_TX_SET,
        ST_TX_HIGH,
        ST_RX_SET,
        ST_RX_HIGH,
        ST_FINISH
    } link_state_t;

endpackage

// File: rtl/dbglink_tick.sv
// Half-period timer: restarts on every tick, so each state lasts HALF cycles.
module dbglink_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == CW'(HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == CW'(HALF - 1));

endmodule

// File: rtl/dbglink_shift.sv
// Byte shifter: reorders command bytes so byte 0 leaves first, MSB first,
// and assembles the reply byte MSB first.
module dbglink_shift #(
    parameter int NBYTES = 4,
    localparam int W = 8 * NBYTES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tx_adv,
    output logic         tx_bit,
    input  logic         rx_clr,
    input  logic         rx_cap,
    input  logic         rx_in,
    output logic [7:0]   rx_byte
);
    logic [W-1:0] ordered;
    logic [W-1:0] tx_sr;
    logic [7:0]   rx_sr;

    for (genvar g = 0; g < NBYTES; g++) begin : g_order
        assign ordered[W-1-8*g -: 8] = load_data[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= ordered;
        end else if (tx_adv) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (rx_clr) begin
            rx_sr <= '0;
        end else if (rx_cap) begin
            rx_sr <= {rx_sr[6:0], rx_in};
        end
    end

    assign tx_bit  = tx_sr[W-1];
    assign rx_byte = rx_sr;

endmodule

// File: rtl/dbglink_master.sv
module dbglink_master
    import dbglink_pkg::*;
#(
    parameter int HALF_CYC     = 2,
    parameter int MAX_BYTES    = 4,
    parameter int ENTRY_PULSES = 2,
    localparam int BCW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_start,
    input  logic [1:0]             cmd_op,
    input  logic [BCW-1:0]         cmd_nbytes_m1,
    input  logic [8*MAX_BYTES-1:0] cmd_bytes,
    output logic                   cmd_ready,
    output logic                   done,
    output logic [7:0]             rx_byte,
    output logic                   link_clk,
    output logic                   link_rst_n,
    output logic                   dio_out,
    output logic                   dio_oe,
    input  logic                   dio_in
);
    localparam int PCW = $clog2(ENTRY_PULSES + 1);

    link_state_t    state, nstate;
    link_op_t       op_q;
    logic [BCW-1:0] nb_q;
    logic [BCW-1:0] byte_cnt;
    logic [2:0]     bit_cnt;
    logic [PCW-1:0] pls_cnt;
    logic           tick;
    logic           accept;
    logic           timer_run;
    logic           tx_bit;

    assign accept    = (state == ST_IDLE) && cmd_start;
    assign timer_run = (state != ST_IDLE) && (state != ST_FINISH);

    dbglink_tick #(.HALF(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (timer_run),
        .tick (tick)
    );

    dbglink_shift #(.NBYTES(MAX_BYTES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(cmd_bytes),
        .tx_adv   (tick && state == ST_TX_HIGH),
        .tx_bit   (tx_bit),
        .rx_clr   (accept),
        .rx_cap   (tick && state == ST_RX_HIGH),
        .rx_in    (dio_in),
        .rx_byte  (rx_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    unique case (link_op_t'(cmd_op))
                        OP_ENTER: nstate = ST_ENT_LOW;
                        OP_EXIT:  nstate = ST_EXT_LOW;
                        OP_WRITE,
                        OP_READ:  nstate = ST_TX_SET;
                        default:  nstate = ST_IDLE;
                    endcase
                end
            end
            ST_ENT_LOW:  if (tick) nstate = ST_ENT_CLKH;
            ST_ENT_CLKH: if (tick) nstate = ST_ENT_CLKL;
            ST_ENT_CLKL: begin
                if (tick) begin
                    nstate = (pls_cnt == PCW'(ENTRY_PULSES)) ? ST_ENT_REL : ST_ENT_CLKH;
                end
            end
            ST_ENT_REL:  if (tick) nstate = ST_FINISH;
            ST_EXT_LOW:  if (tick) nstate = ST_EXT_REL;
            ST_EXT_REL:  if (tick) nstate = ST_FINISH;
            ST_TX_SET:   if (tick) nstate = ST_TX_HIGH;
            ST_TX_HIGH: begin
                if (tick) begin
                    if (bit_cnt != 3'd7 || byte_cnt != nb_q) begin
                        nstate = ST_TX_SET;
                    end else if (op_q == OP_READ) begin
                        nstate = ST_RX_SET;
                    end else begin
                        nstate = ST_FINISH;
                    end
                end
            end
            ST_RX_SET:   if (tick) nstate = ST_RX_HIGH;
            ST_RX_HIGH: begin
                if (tick) begin
                    nstate = (bit_cnt == 3'd7) ? ST_FINISH : ST_RX_SET;
                end
            end
            ST_FINISH:   nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // Operation, bit, byte and pulse counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_WRITE;
            nb_q     <= '0;
            byte_cnt <= '0;
            bit_cnt  <= '0;
            pls_cnt  <= '0;
        end else if (accept) begin
            op_q     <= link_op_t'(cmd_op);
            nb_q     <= cmd_nbytes_m1;
            byte_cnt <= '0;
            bit_cnt  <= '0;
            pls_cnt  <= '0;
        end else if (tick) begin
            if (state == ST_ENT_CLKH) begin
                pls_cnt <= pls_cnt + PCW'(1);
            end
            if (state == ST_TX_HIGH) begin
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_cnt <= byte_cnt + BCW'(1);
                end
            end
            if (state == ST_RX_HIGH) begin
                bit_cnt <= bit_cnt + 3'd1;
            end
        end
    end

    // Output decode
    always_comb begin
        link_clk   = 1'b0;
        link_rst_n = 1'b1;
        dio_oe     = 1'b0;
        cmd_ready  = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:     cmd_ready = 1'b1;
            ST_ENT_LOW,
            ST_ENT_CLKL: link_rst_n = 1'b0;
            ST_ENT_CLKH: begin
                link_rst_n = 1'b0;
                link_clk   = 1'b1;
            end
            ST_EXT_LOW:  link_rst_n = 1'b0;
            ST_ENT_REL,
            ST_EXT_REL,
            ST_RX_SET:   ;
            ST_TX_SET:   dio_oe = 1'b1;
            ST_TX_HIGH: begin
                dio_oe   = 1'b1;
                link_clk = 1'b1;
            end
            ST_RX_HIGH:  link_clk = 1'b1;
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
    end

    assign dio_out = dio_oe & tx_bit;

    // Assertions
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!link_clk && !dio_oe && link_rst_n && !done));

    assert_exit_no_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_EXIT && !cmd_ready) |-> !link_clk);

    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_clk && $past(link_clk) && dio_oe) |-> $stable(dio_out));

    assert_release_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dio_oe) |-> !link_clk);

    assert_state_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |->
            ($past(tick) || $past(state) == ST_IDLE || $past(state) == ST_FINISH));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

endmodule

// File: tb/sim_dbglink_master.sv
module sim_dbglink_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int NB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_nbytes_m1 = 2'd0;
    logic [31:0] cmd_bytes = 32'd0;
    logic        cmd_ready, done, link_clk, link_rst_n, dio_out, dio_oe;
    logic [7:0]  rx_byte;
    logic        dio_in = 1'b0;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbglink_master #(.HALF_CYC(HALF), .MAX_BYTES(NB), .ENTRY_PULSES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_nbytes_m1(cmd_nbytes_m1), .cmd_bytes(cmd_bytes),
        .cmd_ready(cmd_ready), .done(done), .rx_byte(rx_byte),
        .link_clk(link_clk), .link_rst_n(link_rst_n), .dio_out(dio_out),
        .dio_oe(dio_oe), .dio_in(dio_in)
    );

    // Link monitor and target model, on the falling system clock
    int          cyc = 0, last_edge = -1;
    logic        pclk = 1'b0, pdout = 1'b0, poe = 1'b0, hold_val = 1'b0;
    logic [63:0] txs = 64'd0;
    int          ntx = 0, nrx = 0, rise_rstlow = 0, edges = 0;
    int          bad_iv = 0, bad_setup = 0, bad_hold = 0, rst_low_seen = 0, ridx = 0;
    logic [7:0]  reply = 8'd0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && link_clk !== pclk) begin
            edges++;
            if (last_edge >= 0 && (cyc - last_edge) != HALF) bad_iv++;
            last_edge = cyc;
            if (link_clk) begin
                if (!link_rst_n) rise_rstlow++;
                if (dio_oe) begin
                    ntx++;
                    txs = {txs[62:0], dio_out};
                    if (!(poe && pdout == dio_out)) bad_setup++;
                    hold_val = dio_out;
                end else begin
                    nrx++;
                    if (ridx < 8) dio_in = reply[7 - ridx];
                    ridx++;
                end
            end else begin
                dio_in = ~dio_in;
            end
        end else if (link_clk && dio_oe && dio_out !== hold_val) begin
            bad_hold++;
        end
        if (rst_n && !link_rst_n) rst_low_seen++;
        pclk = link_clk; pdout = dio_out; poe = dio_oe;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        txs = 0; ntx = 0; nrx = 0; rise_rstlow = 0; edges = 0; last_edge = -1;
        bad_iv = 0; bad_setup = 0; bad_hold = 0; rst_low_seen = 0; ridx = 0;
    endtask

    function automatic logic [63:0] exp_stream(input int nb, input logic [31:0] b);
        logic [63:0] e = 64'd0;
        for (int i = 0; i < nb; i++) e = {e[55:0], b[8*i +: 8]};
        return e;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input int nb, input logic [31:0] bytes,
                           input logic [7:0] rep, input bit busy_poke,
                           output int dwidth, output logic [7:0] rx);
        int w = 0;
        clear_mon();
        reply = rep;
        cmd_op = op; cmd_nbytes_m1 = 2'(nb - 1); cmd_bytes = bytes; cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
        if (busy_poke) begin
            step(); step(); step();
            cmd_op = 2'd2; cmd_nbytes_m1 = 2'd3; cmd_bytes = 32'hFFFF_FFFF; cmd_start = 1'b1;
            step();
            cmd_start = 1'b0;
            step();
            cmd_op = 2'd1; cmd_start = 1'b1;
            step();
            cmd_start = 1'b0;
        end
        while (!done && w < 5000) begin step(); w++; end
        rx = rx_byte;
        dwidth = 0;
        while (done && dwidth < 10) begin dwidth++; step(); end
    endtask

    task automatic t_reset();
        chk(link_clk == 1'b0, "R1", "reset clk", 64'(link_clk), 0);
        chk(dio_oe == 1'b0, "R1", "reset oe", 64'(dio_oe), 0);
        chk(link_rst_n == 1'b1, "R1", "reset rst_n", 64'(link_rst_n), 1);
        chk(cmd_ready == 1'b1, "R1", "reset ready", 64'(cmd_ready), 1);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 0);
    endtask

    task automatic t_enter();
        int dw; logic [7:0] rx;
        run_cmd(2'd2, 1, 32'd0, 8'd0, 1'b0, dw, rx);
        chk(rise_rstlow == 2, "R2", "rises with reset low", 64'(rise_rstlow), 2);
        chk(edges == 4, "R2", "total clock edges", 64'(edges), 4);
        chk(link_rst_n == 1'b1, "R2", "reset released", 64'(link_rst_n), 1);
        chk(dw == 1, "R9", "enter done width", 64'(dw), 1);
        chk(bad_iv == 0, "R8", "enter half periods", 64'(bad_iv), 0);
    endtask

    task automatic t_exit();
        int dw; logic [7:0] rx;
        run_cmd(2'd3, 1, 32'd0, 8'd0, 1'b0, dw, rx);
        chk(edges == 0, "R3", "exit clock edges", 64'(edges), 0);
        chk(rst_low_seen == HALF, "R3", "exit reset low cycles", 64'(rst_low_seen), HALF);
        chk(link_rst_n == 1'b1, "R3", "exit reset high", 64'(link_rst_n), 1);
        chk(dw == 1, "R9", "exit done width", 64'(dw), 1);
    endtask

    task automatic t_write(input int nb, input logic [31:0] bytes);
        int dw; logic [7:0] rx;
        logic [63:0] e;
        run_cmd(2'd0, nb, bytes, 8'hFF, 1'b0, dw, rx);
        e = exp_stream(nb, bytes);
        chk(ntx == 8*nb, "R4", "write bit count", 64'(ntx), 64'(8*nb));
        chk(txs == e, "R4", "write bit stream", txs, e);
        chk(bad_setup == 0 && bad_hold == 0, "R5", "setup/hold", 64'(bad_setup + bad_hold), 0);
        chk(nrx == 0, "R6", "write receive clocks", 64'(nrx), 0);
        chk(rx == 8'd0, "R6", "write rx_byte", 64'(rx), 0);
        chk(bad_iv == 0, "R8", "write half periods", 64'(bad_iv), 0);
        chk(dw == 1, "R9", "write done width", 64'(dw), 1);
        chk(!link_clk && !dio_oe && cmd_ready, "R1", "idle after write",
            64'({link_clk, dio_oe, cmd_ready}), 64'b001);
    endtask

    task automatic t_read(input int nb, input logic [31:0] bytes, input logic [7:0] rep);
        int dw; logic [7:0] rx;
        logic [63:0] e;
        run_cmd(2'd1, nb, bytes, rep, 1'b0, dw, rx);
        e = exp_stream(nb, bytes);
        chk(txs == e && ntx == 8*nb, "R4", "read command stream", txs, e);
        chk(nrx == 8, "R7", "read receive clocks", 64'(nrx), 8);
        chk(rx == rep, "R7", "read reply byte", 64'(rx), 64'(rep));
        chk(bad_setup == 0 && bad_hold == 0, "R5", "read setup/hold", 64'(bad_setup + bad_hold), 0);
        chk(bad_iv == 0, "R8", "read half periods", 64'(bad_iv), 0);
        chk(dw == 1, "R9", "read done width", 64'(dw), 1);
    endtask

    task automatic t_busy();
        int dw; int e0; logic [7:0] rx;
        run_cmd(2'd0, 1, 32'h0000_005A, 8'h00, 1'b1, dw, rx);
        chk(ntx == 8 && txs[7:0] == 8'h5A, "R10", "busy transfer intact", txs, 64'h5A);
        chk(nrx == 0 && rise_rstlow == 0, "R10", "no foreign activity", 64'(nrx + rise_rstlow), 0);
        e0 = edges;
        for (int i = 0; i < 40; i++) step();
        chk(edges == e0 && cmd_ready, "R10", "no follow-on operation", 64'(edges - e0), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enter();
        t_write(1, 32'h0000_00A5);
        t_write(4, 32'h1234_56C3);
        t_read(2, 32'h0000_E0F0, 8'h3C);
        t_read(4, 32'h8001_7F96, 8'h81);
        t_read(3, 32'h0055_AA0F, 8'h00);
        t_busy();
        t_exit();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule